// File: doc/BRIEF.md
# Comparator Output Deglitch Filter with Edge Interrupt

This block takes the one-bit result of an analog comparator and treats it as an asynchronous digital input. The result is high when the positive input is above the negative input and low otherwise. The block first brings the bit into the CPU clock domain through a synchronizer chain. A hold filter then accepts a new level only after that level has stayed put for a programmable number of clock cycles. A four-bit code sets this hold time. Code 0 gives no hold, and code N gives 2·N cycles, so the longest hold is 30 cycles.

The filtered level drives an edge detector. An edge-select bit chooses whether rising or falling edges count. A qualifying edge sets a sticky interrupt flag, which stays set until software pulses a clear strobe. The interrupt request line is the flag gated by an enable bit. Edges are taken from the filtered level, so a glitch that the filter removes can never raise an interrupt.

Top module: `cmp_deglitch_irq`

## Requirements
- R1: While reset is asserted, and right after it is released, `cmp_filt`, `irq_flag` and `irq_req` are 0, and no edge is reported as a result of reset.
- R2: With `dly_code` = 0, a change on `cmp_raw` appears on `cmp_filt` at the third rising clock edge after `cmp_raw` settles. Two of those edges are synchronizer stages and one is the filter register.
- R3: With `dly_code` = N (1..15), a change on `cmp_raw` appears on `cmp_filt` 2·N clock cycles later than it would with code 0, which is at rising edge 3+2·N. This holds for both rising and falling changes.
- R4: A pulse on `cmp_raw` lasting W cycles reaches `cmp_filt` only if W > 2·N. When it passes, `cmp_filt` is high for exactly W cycles. Otherwise `cmp_filt` does not move.
- R5: If the synchronized input returns to the current filtered level before the hold completes, the count restarts from zero and `cmp_filt` keeps its level.
- R6: With `edge_rise_sel` = 0, a falling edge of `cmp_filt` sets `irq_flag` one cycle after `cmp_filt` falls, and a rising edge does not set it.
- R7: With `edge_rise_sel` = 1, a rising edge of `cmp_filt` sets `irq_flag` one cycle after `cmp_filt` rises, and a falling edge does not set it.
- R8: `irq_flag` stays set until a cycle in which `flag_clr` is 1 and no qualifying edge is present. Such a cycle clears it at the next clock edge.
- R9: If a qualifying edge and `flag_clr` fall in the same cycle, `irq_flag` is 1 afterwards.
- R10: `irq_req` is 1 exactly when `irq_flag` is 1 and `irq_en` is 1.
- R11: The hold length is captured from `dly_code` when a count starts. Changing `dly_code` while a count is running only affects the next transition.
- R12: A pulse on `cmp_raw` that the filter removes never sets `irq_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Raw comparator result, asynchronous |
| dly_code | input | 4 | Hold code: 0 means none, N means 2·N cycles |
| edge_rise_sel | input | 1 | 1 selects rising edges, 0 selects falling edges |
| irq_en | input | 1 | Interrupt request enable |
| flag_clr | input | 1 | Software clear strobe for the flag |
| cmp_filt | output | 1 | Filtered comparator level |
| irq_flag | output | 1 | Sticky edge flag |
| irq_req | output | 1 | Interrupt request, the flag gated by the enable |

## Verification
A filtered edge can land in the same cycle as a software clear strobe. The bench provokes this by driving a falling input with the minimum hold, already knowing at which edge `cmp_filt` drops. It raises `flag_clr` exactly for the following edge, where the flag would be loaded, and the flag must read 1 afterwards. A second collision happens inside the filter: the delay code changes while a count is running. The bench judges it by timing the rising and the falling transition, which must follow the old code and the new code respectively.

// File: rtl/cmp_filt_pkg.sv
package cmp_filt_pkg;

  // Hold length in clock cycles for a given delay code.
  function automatic int hold_cycles(input int code, input int step);
    return code * step;
  endfunction

  // Width needed to count up to a maximum value.
  function automatic int count_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/cmp_hold_filter.sv
module cmp_hold_filter
  import cmp_filt_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic [CODE_W-1:0] code,
  output logic              dout,
  output logic              start_evt,
  output logic              commit_evt
);
  localparam int MAX_HOLD = STEP * ((1 << CODE_W) - 1);
  localparam int CNT_W    = count_width(MAX_HOLD);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_now;
  logic             differ;
  logic             counting;

  assign lim_now    = CNT_W'(hold_cycles(int'(code), STEP));
  assign differ     = (din != dout);
  assign counting   = (cnt != '0);
  assign start_evt  = differ && !counting && (lim_now != '0);
  assign commit_evt = differ && ((!counting && (lim_now == '0)) ||
                                 (counting && (cnt == lim_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      lim_q <= '0;
      dout  <= 1'b0;
    end else if (!differ) begin
      cnt <= '0;
    end else if (commit_evt) begin
      cnt  <= '0;
      dout <= din;
    end else if (start_evt) begin
      cnt   <= CNT_W'(1);
      lim_q <= lim_now;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // The output only ever moves toward the synchronized input.
  assert_move_toward_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> (dout == $past(din)));

  // A running count never passes the hold length captured at its start.
  assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt <= lim_q));

  // When the input agrees with the output, the count restarts.
  assert_revert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !differ |=> (cnt == '0));

endmodule

// File: rtl/cmp_edge_flag.sv
module cmp_edge_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic rise_sel,
  input  logic clr,
  output logic flag,
  output logic hit
);
  logic prev;
  logic rise_evt;
  logic fall_evt;

  assign rise_evt = level && !prev;
  assign fall_evt = !level && prev;
  assign hit      = rise_sel ? rise_evt : fall_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      flag <= 1'b0;
    end else begin
      prev <= level;
      flag <= hit | (flag & ~clr);
    end
  end

  // An edge wins over a clear that arrives in the same cycle.
  assert_hit_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);

  // Without a clear, the flag holds its value.
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  // The flag only rises after an edge of the selected polarity.
  assert_rise_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(rise_sel ? (level && !prev) : (!level && prev)));

endmodule

// File: rtl/cmp_deglitch_irq.sv
module cmp_deglitch_irq #(
  parameter int CODE_W      = 4,
  parameter int STEP        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_raw,
  input  logic [CODE_W-1:0] dly_code,
  input  logic              edge_rise_sel,
  input  logic              irq_en,
  input  logic              flag_clr,
  output logic              cmp_filt,
  output logic              irq_flag,
  output logic              irq_req
);
  logic raw_sync;
  logic filt_start;
  logic filt_commit;
  logic edge_hit;

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cmp_raw),
    .d_sync  (raw_sync)
  );

  cmp_hold_filter #(.CODE_W(CODE_W), .STEP(STEP)) u_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (raw_sync),
    .code       (dly_code),
    .dout       (cmp_filt),
    .start_evt  (filt_start),
    .commit_evt (filt_commit)
  );

  cmp_edge_flag u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (cmp_filt),
    .rise_sel (edge_rise_sel),
    .clr      (flag_clr),
    .flag     (irq_flag),
    .hit      (edge_hit)
  );

  assign irq_req = irq_flag & irq_en;

  // Edges come from the filtered level: the filter commits a change one cycle
  // before the edge detector can report it.
  assert_edge_after_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |-> $past(filt_commit));

  // A request needs an enabled flag.
  assert_req_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_flag && irq_en));

  // No flag appears in the cycle right after reset.
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq_flag);

endmodule

// File: tb/tb_cmp_deglitch_irq.sv
`timescale 1ns/1ps
module tb_cmp_deglitch_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_raw = 1'b0;
  logic [3:0] dly_code = 4'd0;
  logic       edge_rise_sel = 1'b1;
  logic       irq_en = 1'b1;
  logic       flag_clr = 1'b0;
  logic       cmp_filt;
  logic       irq_flag;
  logic       irq_req;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  cmp_deglitch_irq dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmp_raw       (cmp_raw),
    .dly_code      (dly_code),
    .edge_rise_sel (edge_rise_sel),
    .irq_en        (irq_en),
    .flag_clr      (flag_clr),
    .cmp_filt      (cmp_filt),
    .irq_flag      (irq_flag),
    .irq_req       (irq_req)
  );

  // Pulse vectors: delay code and raw pulse width in cycles.
  localparam int NV = 12;
  localparam int VEC_CODE [NV] = '{0, 1, 1, 3, 3, 7, 7, 15, 15, 2, 2, 5};
  localparam int VEC_W    [NV] = '{1, 2, 3, 6, 7, 14, 15, 30, 31, 4, 5, 11};

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Counts rising edges until cmp_filt reaches the target level.
  task automatic edges_until(input logic target, output int k);
    k = 0;
    for (int i = 1; i <= 100; i++) begin
      @(posedge clk); #1;
      if (cmp_filt == target) begin
        k = i;
        break;
      end
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  // Raw pulse of w cycles, returning how many samples saw cmp_filt high.
  task automatic pulse(input int code, input int w, output int hi);
    hi = 0;
    @(negedge clk);
    dly_code = 4'(code);
    cmp_raw  = 1'b1;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      if (cmp_filt) hi++;
    end
    cmp_raw = 1'b0;
    for (int i = 0; i < 2 * code + 8; i++) begin
      @(negedge clk);
      if (cmp_filt) hi++;
    end
  endtask

  initial begin
    #900000;
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    int hi;
    int exp_hi;

    // R1: reset state, with the raw bit already high
    cmp_raw = 1'b1;
    settle(3);
    chk("R1 filt in reset", cmp_filt, 0);
    chk("R1 flag in reset", irq_flag, 0);
    chk("R1 req in reset", irq_req, 0);
    cmp_raw = 1'b0;
    settle(3);
    rst_n = 1'b1;
    settle(4);
    chk("R1 filt after reset", cmp_filt, 0);
    chk("R1 flag after reset", irq_flag, 0);
    chk("R1 req after reset", irq_req, 0);

    // Table: R4 pass/block and width, R7 rising flag, R12 filtered glitch, R10 req
    edge_rise_sel = 1'b1;
    irq_en = 1'b1;
    for (int v = 0; v < NV; v++) begin
      pulse(VEC_CODE[v], VEC_W[v], hi);
      exp_hi = (VEC_W[v] > 2 * VEC_CODE[v]) ? VEC_W[v] : 0;
      chk($sformatf("R4 width code=%0d w=%0d", VEC_CODE[v], VEC_W[v]), hi, exp_hi);
      chk($sformatf("R7/R12 flag code=%0d w=%0d", VEC_CODE[v], VEC_W[v]),
          irq_flag, (exp_hi != 0) ? 1 : 0);
      chk($sformatf("R10 req code=%0d w=%0d", VEC_CODE[v], VEC_W[v]),
          irq_req, (exp_hi != 0) ? 1 : 0);
      clear_flag();
      settle(2);
    end

    // R2: latency with code 0
    @(negedge clk) begin dly_code = 4'd0; cmp_raw = 1'b1; end
    edges_until(1'b1, k);
    chk("R2 rise latency code0", k, 3);
    @(negedge clk) cmp_raw = 1'b0;
    edges_until(1'b0, k);
    chk("R2 fall latency code0", k, 3);
    clear_flag();

    // R3: latency with code 5
    @(negedge clk) begin dly_code = 4'd5; cmp_raw = 1'b1; end
    edges_until(1'b1, k);
    chk("R3 rise latency code5", k, 13);
    @(negedge clk) cmp_raw = 1'b0;
    edges_until(1'b0, k);
    chk("R3 fall latency code5", k, 13);
    clear_flag();
    settle(3);

    // R5: one-cycle reversion restarts the count (code 3 needs 7 cycles)
    hi = 0;
    @(negedge clk) begin dly_code = 4'd3; cmp_raw = 1'b1; end
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (cmp_filt) hi++; end
    cmp_raw = 1'b0;
    @(negedge clk); if (cmp_filt) hi++;
    cmp_raw = 1'b1;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (cmp_filt) hi++; end
    cmp_raw = 1'b0;
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (cmp_filt) hi++; end
    chk("R5 reverted pulse blocked", hi, 0);
    chk("R5 no flag", irq_flag, 0);

    // R6: falling polarity
    edge_rise_sel = 1'b0;
    @(negedge clk) begin dly_code = 4'd0; cmp_raw = 1'b1; end
    settle(6);
    chk("R6 filt high", cmp_filt, 1);
    chk("R6 rising ignored", irq_flag, 0);
    cmp_raw = 1'b0;
    settle(6);
    chk("R6 falling sets flag", irq_flag, 1);

    // R8: sticky, then cleared by the strobe
    settle(20);
    chk("R8 flag held", irq_flag, 1);
    // R10: enable gating
    irq_en = 1'b0; #1;
    chk("R10 req masked", irq_req, 0);
    irq_en = 1'b1; #1;
    chk("R10 req enabled", irq_req, 1);
    clear_flag();
    chk("R8 flag cleared", irq_flag, 0);

    // R9: edge and clear in the same cycle; flag preset to 1 first
    @(negedge clk) cmp_raw = 1'b1;
    settle(6);
    @(negedge clk) cmp_raw = 1'b0;
    settle(6);
    chk("R9 preset flag", irq_flag, 1);
    @(negedge clk) cmp_raw = 1'b1;
    settle(6);
    @(negedge clk) cmp_raw = 1'b0;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R9 filt fell", cmp_filt, 0);
    flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    chk("R9 edge beats clear", irq_flag, 1);
    clear_flag();
    chk("R9 later clear", irq_flag, 0);

    // R11: code change mid-count affects only the next transition
    edge_rise_sel = 1'b1;
    @(negedge clk) begin dly_code = 4'd2; cmp_raw = 1'b1; end
    k = 0;
    for (int i = 1; i <= 60; i++) begin
      @(posedge clk); #1;
      if (i == 4) dly_code = 4'd10;
      if (cmp_filt && k == 0) k = i;
    end
    chk("R11 rise uses old code", k, 7);
    @(negedge clk) cmp_raw = 1'b0;
    edges_until(1'b0, k);
    chk("R11 fall uses new code", k, 23);
    clear_flag();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule